// File: doc/BRIEF.md
# Key-Protected Flash Row Controller

This block is the nonvolatile memory controller placed between a CPU register bus and the command port of a flash array. Software stages one row of 32 words in a write buffer through table writes. Each table write also latches the row address, formed from a page register and a 16-bit in-page offset. Software then sets a control register with an operation code, an erase flag and a write-enable flag. To launch an erase or a program of that row, it must first write the two-byte unlock key and then set the start flag.

During the operation the controller drives one array write per cycle for the 32 words of the row. An erase writes all-ones. A program writes the buffered words. The operation lasts a fixed number of clock cycles, `OP_CYCLES`, and the CPU stall output stays high for all of them. The start flag reads back as set while the operation runs and clears itself in the same cycle that the stall drops.

A start without a fresh unlock fails and the array is left alone. So does a start with the wrong operation code or with write-enable clear. A failed start sets a sticky error flag, and the next valid start clears it.

Top module: `nvm_row_ctrl`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x0000 and `cpu_stall` and `arr_we` are both low.
- R2: A control write (`reg_addr`=0) with bit 15 clear stores bit 14 (erase), bit 6 (write-enable) and bits 5:0 (operation code). These appear on `ctrl_rd` at the same positions one cycle later. Bit 13 of `ctrl_rd` is the error flag and bit 15 is the start/busy flag.
- R3: A control write with bit 15 set is accepted only if the two register writes just before it were key writes (`reg_addr`=1) of 0x55 and then 0xAA. A wrong byte, the reverse order, or any other register write in between voids the unlock.
- R4: A start attempt consumes the unlock, so a second start with no new key pair fails.
- R5: A start that fails has several possible causes: no unlock, write-enable clear, or an operation code other than 6'b011000. Any failed start produces no array write, leaves bit 15 at 0 and sets the error flag.
- R6: An erase (bit 14 set) writes all-ones to the 32 words of the latched row.
- R7: A program (bit 14 clear) writes buffer entry i to row word i, for i = 0..31.
- R8: A table write stores `tbl_data` in buffer entry `tbl_offset[4:0]`. It also latches the row base `{page, tbl_offset[15:5], 5'b0}`, where page is the low 8 bits last written to `reg_addr`=2. Array address i of the row is that base plus i.
- R9: `cpu_stall` and `ctrl_rd[15]` are high for exactly `OP_CYCLES` cycles from the cycle after an accepted start. Both drop in the same cycle.
- R10: While `cpu_stall` is high, register writes and table writes are ignored. This includes key writes and the control fields.
- R11: An accepted start clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 key, 2 page |
| reg_wdata | input | 16 | Register write data |
| ctrl_rd | output | 16 | Control/status readback |
| tbl_wr | input | 1 | Table write strobe |
| tbl_offset | input | 16 | In-page word offset |
| tbl_data | input | WORD_W | Word to buffer |
| cpu_stall | output | 1 | CPU stall during operation |
| arr_we | output | 1 | Array write command |
| arr_addr | output | PAGE_W+16 | Array word address |
| arr_wdata | output | WORD_W | Array write data |

## Verification
The end of an operation and a new register write can land in the same cycle. On that edge the start flag clears and the stall drops, while the write must still be treated as arriving during the operation. The bench provokes this by issuing key byte 0x55 in the last stalled cycle, followed by 0xAA and a start. It judges the result at the ports: the stall and the start flag must have dropped together, and the start must fail with the error flag set and no array write. A table of key, gap and control patterns also covers the ways an unlock can break.

// File: rtl/nvm_row_pkg.sv
package nvm_row_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [5:0] OP_ROW     = 6'b011000;
    localparam int START_BIT = 15;
    localparam int ERASE_BIT = 14;
    localparam int WREN_BIT  = 6;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_KEY  = 2'd1,
        SEL_PAGE = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_HALF = 2'd1,
        K_OPEN = 2'd2
    } key_st_e;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_row_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       other_wr,
    output logic       unlocked
);
    key_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            if (key_byte == KEY_FIRST)
                st_d = K_HALF;
            else if (key_byte == KEY_SECOND && st_q == K_HALF)
                st_d = K_OPEN;
            else
                st_d = K_IDLE;
        end else if (other_wr) begin
            st_d = K_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= K_IDLE;
        else        st_q <= st_d;
    end

    assign unlocked = (st_q == K_OPEN);

    // R3: opening only directly after the second key byte
    p_open_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_wr && key_byte == KEY_SECOND));

    // R4: any non-key register write consumes the unlock
    p_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> !unlocked);
endmodule

// File: rtl/nvm_row_buf.sv
module nvm_row_buf #(
    parameter int WORD_W    = 24,
    parameter int ROW_WORDS = 32,
    localparam int IDX_W    = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [ROW_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/nvm_row_ctrl.sv
module nvm_row_ctrl
    import nvm_row_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int ROW_WORDS = 32,
    parameter int PAGE_W    = 8,
    parameter int OP_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         ctrl_rd,
    input  logic                tbl_wr,
    input  logic [15:0]         tbl_offset,
    input  logic [WORD_W-1:0]   tbl_data,
    output logic                cpu_stall,
    output logic                arr_we,
    output logic [PAGE_W+15:0]  arr_addr,
    output logic [WORD_W-1:0]   arr_wdata
);
    localparam int IDX_W  = $clog2(ROW_WORDS);
    localparam int CNT_W  = $clog2(OP_CYCLES);
    localparam int BASE_W = PAGE_W + 16 - IDX_W;
    localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_CYCLES - 1);
    localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(ROW_WORDS - 1);

    typedef struct packed {
        logic              busy;
        logic              ers;
        logic              wren;
        logic [5:0]        op;
        logic              err;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
        logic [BASE_W-1:0] base;
    } state_t;

    state_t st_d, st_q;

    logic ctrl_wr, key_wr, other_wr, unlocked, buf_wr;
    logic [WORD_W-1:0] buf_rd;
    logic unused_bits;

    assign unused_bits = ^reg_wdata[13:7];

    assign ctrl_wr  = reg_wr && !st_q.busy && reg_addr == SEL_CTRL;
    assign key_wr   = reg_wr && !st_q.busy && reg_addr == SEL_KEY;
    assign other_wr = reg_wr && !st_q.busy && reg_addr != SEL_KEY;
    assign buf_wr   = tbl_wr && !st_q.busy;

    nvm_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (reg_wdata[7:0]),
        .other_wr (other_wr),
        .unlocked (unlocked)
    );

    nvm_row_buf #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_idx  (tbl_offset[IDX_W-1:0]),
        .wr_data (tbl_data),
        .rd_idx  (st_q.cnt[IDX_W-1:0]),
        .rd_data (buf_rd)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == OP_LAST) st_d.busy = 1'b0;
        end
        if (ctrl_wr) begin
            st_d.ers  = reg_wdata[ERASE_BIT];
            st_d.wren = reg_wdata[WREN_BIT];
            st_d.op   = reg_wdata[5:0];
            if (reg_wdata[START_BIT]) begin
                if (unlocked && reg_wdata[WREN_BIT] && reg_wdata[5:0] == OP_ROW) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.err  = 1'b0;
                end else begin
                    st_d.err  = 1'b1;
                end
            end
        end
        if (reg_wr && !st_q.busy && reg_addr == SEL_PAGE)
            st_d.page = reg_wdata[PAGE_W-1:0];
        if (buf_wr)
            st_d.base = {st_q.page, tbl_offset[15:IDX_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_stall = st_q.busy;
    assign ctrl_rd   = {st_q.busy, st_q.ers, st_q.err, 6'b0, st_q.wren, st_q.op};
    assign arr_we    = st_q.busy && (st_q.cnt <= ROW_LAST);
    assign arr_addr  = {st_q.base, st_q.cnt[IDX_W-1:0]};
    assign arr_wdata = st_q.ers ? {WORD_W{1'b1}} : buf_rd;

    // R5: the array is only touched during an accepted operation
    p_no_idle_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> !arr_we);

    // R5: a rising error flag never comes with a started operation
    p_err_no_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rd[13]) |-> !cpu_stall);

    // R6: erase data is all-ones
    p_erase_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && ctrl_rd[ERASE_BIT]) |-> (&arr_wdata));

    // R9: the stall continues until the final count
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != OP_LAST) |=> st_q.busy);

    // R9: the stall ends right after the final count
    p_stall_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == OP_LAST) |=> !st_q.busy);

    // R10: control fields and page are frozen while stalled
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable({st_q.ers, st_q.wren, st_q.op, st_q.page, st_q.base}));

    // R11: a started operation carries a clear error flag
    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> !ctrl_rd[13]);
endmodule

// File: tb/sim_nvm_row_ctrl.sv
module sim_nvm_row_ctrl;
    localparam int OPC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl_rd;
    logic        tbl_wr = 1'b0;
    logic [15:0] tbl_offset = '0;
    logic [23:0] tbl_data = '0;
    logic        cpu_stall, arr_we;
    logic [23:0] arr_addr, arr_wdata;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    bit finished = 0;
    logic [23:0] mem [int unsigned];

    always #10 clk = ~clk;

    nvm_row_ctrl #(.OP_CYCLES(OPC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .tbl_wr(tbl_wr),
        .tbl_offset(tbl_offset), .tbl_data(tbl_data), .cpu_stall(cpu_stall),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always @(posedge clk) begin
        if (arr_we) begin
            mem[int'(arr_addr)] = arr_wdata;
            wcount++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tbl_write(input logic [15:0] off, input logic [23:0] d);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_offset = off; tbl_data = d;
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic keys();
        reg_write(2'd1, 16'h0055);
        reg_write(2'd1, 16'h00AA);
    endtask

    function automatic logic [23:0] pdat(input int i);
        return 24'h5A0000 | (24'(i) * 24'h000111);
    endfunction

    // k1 | k2 | gap | ctrl | ok
    localparam logic [33:0] VECS [0:6] = '{
        {8'h55, 8'hAA, 1'b0, 16'hC058, 1'b1},
        {8'hAA, 8'h55, 1'b0, 16'hC058, 1'b0},
        {8'h55, 8'hAA, 1'b1, 16'hC058, 1'b0},
        {8'h55, 8'hAA, 1'b0, 16'h8018, 1'b0},
        {8'h55, 8'hAA, 1'b0, 16'hC059, 1'b0},
        {8'h55, 8'hAA, 1'b0, 16'h8058, 1'b1},
        {8'h55, 8'h54, 1'b0, 16'hC058, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0, n, bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ctrl_rd == 16'h0000, "R1 ctrl_rd", ctrl_rd, 0);
        check(!cpu_stall && !arr_we, "R1 stall/we", {cpu_stall, arr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        reg_write(2'd2, 16'h0003);
        tbl_write(16'h0140, 24'h000001);

        // vector table: R3 R4 R5 R11
        for (int v = 0; v < 7; v++) begin
            logic [33:0] e;
            e = VECS[v];
            w0 = wcount;
            reg_write(2'd1, {8'h00, e[33:26]});
            reg_write(2'd1, {8'h00, e[25:18]});
            if (e[17]) reg_write(2'd2, 16'h0003);
            reg_write(2'd0, e[16:1]);
            repeat (OPC + 4) @(negedge clk);
            check((wcount - w0) == (e[0] ? 32 : 0), "R3/R5 writes", wcount - w0, e[0] ? 32 : 0);
            check(ctrl_rd[13] == !e[0], "R5/R11 err flag", ctrl_rd[13], !e[0]);
            check(ctrl_rd[15] == 1'b0, "R9 start cleared", ctrl_rd[15], 0);
        end

        // R2 field storage without start
        reg_write(2'd0, 16'h4058);
        check(ctrl_rd == 16'h4058 || ctrl_rd == 16'h6058, "R2 fields", ctrl_rd, 16'h4058);

        // R6 R8 R9 erase of row {03, 0x0140}
        mem.delete();
        tbl_write(16'h0147, 24'h000000);
        keys();
        w0 = wcount;
        reg_write(2'd0, 16'hC058);
        check(ctrl_rd[15] == 1'b1, "R9 start flag during run", ctrl_rd[15], 1);
        n = 0;
        while (cpu_stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == OPC, "R9 stall length", n, OPC);
        check(ctrl_rd == 16'h4058, "R9/R11 ctrl after erase", ctrl_rd, 16'h4058);
        check(wcount - w0 == 32, "R6 write count", wcount - w0, 32);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            int unsigned a;
            a = 32'h030140 + 32'(i);
            if (!mem.exists(a) || mem[a] != 24'hFFFFFF) bad++;
        end
        check(bad == 0, "R6/R8 erased row", bad, 0);
        check(!mem.exists(32'h030160), "R8 next row untouched", mem.exists(32'h030160), 0);

        // R7 R8 R10 program
        for (int i = 0; i < 32; i++) tbl_write(16'h0140 + 16'(i), pdat(i));
        keys();
        w0 = wcount;
        reg_write(2'd0, 16'h8058);
        tbl_write(16'h015F, 24'hDEAD00);  // R10 ignored
        reg_write(2'd0, 16'h0000);        // R10 ignored
        reg_write(2'd2, 16'h0007);        // R10 ignored
        repeat (OPC) @(negedge clk);
        check(ctrl_rd == 16'h0058, "R10 ctrl kept", ctrl_rd, 16'h0058);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            int unsigned a;
            a = 32'h030140 + 32'(i);
            if (!mem.exists(a) || mem[a] != pdat(i)) bad++;
        end
        check(bad == 0, "R7 programmed row", bad, 0);
        check(mem[32'h03015F] == pdat(31), "R10 buffer kept", mem[32'h03015F], pdat(31));

        // R4 second start without keys
        w0 = wcount;
        reg_write(2'd0, 16'h8058);
        repeat (OPC + 4) @(negedge clk);
        check(wcount == w0, "R4 no writes", wcount - w0, 0);
        check(ctrl_rd[13] == 1'b1, "R4 err", ctrl_rd[13], 1);

        // R9 R10 key write in last stalled cycle
        keys();
        reg_write(2'd0, 16'hC058);
        repeat (OPC - 1) @(negedge clk);
        check(cpu_stall == 1'b1, "R9 last stall cycle", cpu_stall, 1);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0055;
        @(negedge clk);
        reg_wr = 1'b0;
        check(!cpu_stall && !ctrl_rd[15], "R9 drop together", {cpu_stall, ctrl_rd[15]}, 0);
        w0 = wcount;
        reg_write(2'd1, 16'h00AA);
        reg_write(2'd0, 16'hC058);
        repeat (OPC + 4) @(negedge clk);
        check(wcount == w0, "R10 key in busy ignored", wcount - w0, 0);
        check(ctrl_rd[13] == 1'b1, "R10 err after broken key", ctrl_rd[13], 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule